// File: doc/BRIEF.md
# Oversampling I2C Bit Receiver

This block reads a single data bit from an I2C target while acting as bus controller. It drives SCL and SDA through open-drain enables and reads the two lines through inputs that are already synchronized. A one-cycle request starts a bit cycle. The block first waits for SCL to read high. It then pulls SCL low for a fixed delay with SDA released, and releases SCL again. A target may stretch the clock at both waits. After a settle delay the block samples SDA several times while SCL is high.

Each high sample adds four to an accumulator and each low sample adds nothing. The final total falls into one of three bands. A clean low gives bit 0, a clean high gives bit 1, and anything in between is reported as a receive error. A short spike on SDA therefore cannot flip a bit. A request made while no bus transaction is open is refused, and the lines are left as they are. A clock held low for longer than a programmable limit gives a bus-lock error. Byte assembly, acknowledge and START/STOP generation are handled by the logic around this block.

Top module: `sda_vote_rx`

## Requirements
- R1: A request while `bus_active_i` is low produces a result one cycle later with `err_o` = 1 (bad state) and `bit_o` = 0, and SCL and SDA stay released.
- R2: After a request the block does not pull SCL low until it has sampled `scl_i` high; while a target holds SCL low, `scl_oe_o` stays 0.
- R3: The SCL low phase lasts exactly `DELAY_CYC` cycles, and `sda_oe_o` is 0 throughout it.
- R4: After SCL is released, sampling starts only once `scl_i` reads high, followed by `DELAY_CYC` settle cycles; a stretch of up to the limit still yields the correct bit.
- R5: SDA is sampled `N_SAMPLES` times, `GAP_CYC` cycles apart, with the first sample `DELAY_CYC`+1 cycles after the edge at which SCL was seen high. Values present between sample instants have no effect.
- R6: If four times the number of high samples is below `N_SAMPLES`, the result is `err_o` = 0 with `bit_o` = 0.
- R7: If four times the number of high samples is at least 3·`N_SAMPLES`, the result is `err_o` = 0 with `bit_o` = 1.
- R8: Any count between those bands gives `err_o` = 3 (receive error) with `bit_o` = 0.
- R9: In either SCL wait, if `scl_i` is sampled low on more than `stretch_limit_i` consecutive edges, the result is `err_o` = 2 (bus lock); exactly `stretch_limit_i` low edges is still accepted.
- R10: When `valid_o` is high, and afterwards until the next request, `scl_oe_o` and `sda_oe_o` are both 0.
- R11: Each accepted request yields exactly one `valid_o` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_active_i | input | 1 | High while a transaction is open (START issued) |
| req_i | input | 1 | One-cycle request to read one bit |
| stretch_limit_i | input | TO_W | Maximum number of consecutive low SCL samples tolerated in a wait |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low (always released by this block) |
| valid_o | output | 1 | One-cycle result strobe |
| bit_o | output | 1 | Received bit, valid when err_o is 0 |
| err_o | output | 2 | 0 ok, 1 bad state, 2 bus lock, 3 receive error |

## Verification
The bench builds the block with eight samples, a delay of three cycles and a gap of two, and runs with a stretch limit of five. Eight samples make every band boundary reachable: one versus two high samples, and five versus six. The two-cycle gap leaves an idle cycle between sample instants. The bench drives the opposite SDA value in that cycle to show that only the sample instants count. A limit of five keeps both sides of the lock boundary, five and six low edges, within a few cycles.

// File: rtl/sda_vote_rx_pkg.sv
`timescale 1ns/1ps
package sda_vote_rx_pkg;
  typedef enum logic [1:0] {
    RX_OK        = 2'd0,
    RX_BAD_STATE = 2'd1,
    RX_BUS_LOCK  = 2'd2,
    RX_GARBLED   = 2'd3
  } rx_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_LOW,
    ST_WAIT_STR,
    ST_SETTLE,
    ST_SAMPLE,
    ST_DECIDE
  } rx_state_e;
endpackage

// File: rtl/sda_vote_rx_cnt.sv
`timescale 1ns/1ps
module sda_vote_rx_cnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sda_vote_rx_acc.sv
`timescale 1ns/1ps
module sda_vote_rx_acc #(
  parameter int N_SAMPLES = 8,
  localparam int ACC_W = $clog2(4 * N_SAMPLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             sda_i,
  output logic [ACC_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_o <= '0;
    else if (clr_i)             acc_o <= '0;
    else if (take_i && sda_i)   acc_o <= acc_o + ACC_W'(4);
  end
endmodule

// File: rtl/sda_vote_rx.sv
`timescale 1ns/1ps
module sda_vote_rx
  import sda_vote_rx_pkg::*;
#(
  parameter int N_SAMPLES = 8,
  parameter int DELAY_CYC = 4,
  parameter int GAP_CYC   = 2,
  parameter int TO_W      = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_active_i,
  input  logic            req_i,
  input  logic [TO_W-1:0] stretch_limit_i,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe_o,
  output logic            sda_oe_o,
  output logic            valid_o,
  output logic            bit_o,
  output logic [1:0]      err_o
);
  localparam int ACC_W = $clog2(4 * N_SAMPLES + 1);
  localparam int IDX_W = (N_SAMPLES > 1) ? $clog2(N_SAMPLES) : 1;
  localparam logic [ACC_W-1:0] LO_TH = ACC_W'(N_SAMPLES);
  localparam logic [ACC_W-1:0] HI_TH = ACC_W'(3 * N_SAMPLES);
  localparam logic [TO_W-1:0]  DLY_LAST = TO_W'(DELAY_CYC - 1);
  localparam logic [TO_W-1:0]  GAP_LAST = TO_W'(GAP_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_SAMPLES - 1);

  rx_state_e        state_q, state_d;
  logic [TO_W-1:0]  cnt;
  logic             cnt_clr;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [ACC_W-1:0] acc;
  logic             vote_clr, take;
  logic             res_set, res_bit;
  rx_err_e          res_err, err_q;
  logic             valid_q, bit_q;

  sda_vote_rx_cnt #(.W(TO_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  sda_vote_rx_acc #(.N_SAMPLES(N_SAMPLES)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (vote_clr),
    .take_i(take),
    .sda_i (sda_i),
    .acc_o (acc)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cnt_clr  = 1'b0;
    vote_clr = 1'b0;
    take     = 1'b0;
    res_set  = 1'b0;
    res_err  = RX_OK;
    res_bit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr  = 1'b1;
        vote_clr = 1'b1;
        if (req_i) begin
          if (!bus_active_i) begin
            res_set = 1'b1;
            res_err = RX_BAD_STATE;
          end else begin
            state_d = ST_WAIT_HI;
          end
        end
      end
      ST_WAIT_HI, ST_WAIT_STR: begin
        if (scl_i) begin
          cnt_clr = 1'b1;
          state_d = (state_q == ST_WAIT_HI) ? ST_LOW : ST_SETTLE;
        end else if (cnt == stretch_limit_i) begin
          res_set = 1'b1;
          res_err = RX_BUS_LOCK;
          state_d = ST_IDLE;
        end
      end
      ST_LOW: begin
        if (cnt == DLY_LAST) begin
          cnt_clr = 1'b1;
          state_d = ST_WAIT_STR;
        end
      end
      ST_SETTLE: begin
        if (cnt == DLY_LAST) begin
          cnt_clr = 1'b1;
          idx_d   = '0;
          state_d = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        take = (cnt == '0);
        if (cnt == GAP_LAST) begin
          cnt_clr = 1'b1;
          if (idx_q == IDX_LAST) state_d = ST_DECIDE;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      ST_DECIDE: begin
        res_set = 1'b1;
        state_d = ST_IDLE;
        if (acc < LO_TH)       res_bit = 1'b0;
        else if (acc >= HI_TH) res_bit = 1'b1;
        else                   res_err = RX_GARBLED;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      err_q   <= RX_OK;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      valid_q <= res_set;
      if (res_set) begin
        bit_q <= res_bit;
        err_q <= res_err;
      end
    end
  end

  assign scl_oe_o = (state_q == ST_LOW);
  assign sda_oe_o = 1'b0;  // target owns SDA for the whole read bit
  assign valid_o  = valid_q;
  assign bit_o    = bit_q;
  assign err_o    = err_q;
endmodule

// File: rtl/sda_vote_rx_chk.sv
`timescale 1ns/1ps
module sda_vote_rx_chk #(
  parameter int DELAY_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_active_i,
  input logic       scl_i,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       valid_o,
  input logic       bit_o,
  input logic [1:0] err_o
);
  logic [15:0] low_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_run <= '0;
    else if (scl_oe_o) low_run <= low_run + 1'b1;
    else               low_run <= '0;
  end

  // R1
  bad_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o == 2'd1) |-> (!$past(bus_active_i) && !$past(scl_oe_o)));
  // R2
  pull_after_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> $past(scl_i));
  // R3
  low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> (low_run == 16'(DELAY_CYC)));
  // R3
  sda_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> !sda_oe_o);
  // R8
  garbled_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o != 2'd0) |-> !bit_o);
  // R10
  released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!scl_oe_o && !sda_oe_o));
  // R11
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

bind sda_vote_rx sda_vote_rx_chk #(.DELAY_CYC(DELAY_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_active_i(bus_active_i),
  .scl_i       (scl_i),
  .scl_oe_o    (scl_oe_o),
  .sda_oe_o    (sda_oe_o),
  .valid_o     (valid_o),
  .bit_o       (bit_o),
  .err_o       (err_o)
);

// File: tb/sda_vote_rx_test.sv
`timescale 1ns/1ps
module sda_vote_rx_test;
  localparam int NS = 8;
  localparam int D  = 3;
  localparam int G  = 2;
  localparam int TW = 12;
  localparam int LIM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_act = 1'b1;
  logic req = 1'b0;
  logic [TW-1:0] lim = TW'(LIM);
  logic tgt_hold = 1'b0;
  logic tgt_sda = 1'b1;
  logic scl_oe, sda_oe, valid, rbit;
  logic [1:0] err;
  logic scl_line, sda_line;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  assign scl_line = !scl_oe && !tgt_hold;
  assign sda_line = !sda_oe && tgt_sda;

  always #2.5 clk = ~clk;

  sda_vote_rx #(.N_SAMPLES(NS), .DELAY_CYC(D), .GAP_CYC(G), .TO_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_active_i(bus_act), .req_i(req),
    .stretch_limit_i(lim), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .valid_o(valid), .bit_o(rbit), .err_o(err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [2:0] expect_of(input logic [NS-1:0] pat);
    int t = 4 * $countones(pat);
    if (t < NS)      return {1'b0, 2'd0};   // R6
    if (t >= 3 * NS) return {1'b1, 2'd0};   // R7
    return {1'b0, 2'd3};                    // R8
  endfunction

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int g = 0; g < 60 && !seen; g++) begin
      if (valid) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic run_bit(input logic [NS-1:0] pat, input int s1, input int s2);
    logic [2:0] e = expect_of(pat);
    int lowc = 0;
    bit seen;
    tgt_sda = 1'b1;
    tgt_hold = (s1 > 0);
    pulse_req();
    for (int i = 0; i < s1; i++) begin
      chk(!scl_oe, "R2 scl pulled while held", scl_oe, 0);
      @(negedge clk);
    end
    tgt_hold = 1'b0;
    for (int g = 0; g < 20 && !scl_oe; g++) @(negedge clk);
    while (scl_oe && lowc < 50) begin
      lowc++;
      if (sda_oe) chk(1'b0, "R3 sda driven in low phase", sda_oe, 0);
      @(negedge clk);
    end
    chk(lowc == D, "R3 low phase length", lowc, D);
    tgt_hold = (s2 > 0);
    for (int i = 0; i < s2; i++) begin
      if (valid) chk(1'b0, "R4 result during stretch", valid, 0);
      @(negedge clk);
    end
    tgt_hold = 1'b0;
    repeat (D + 1) @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      tgt_sda = pat[k];
      @(negedge clk);
      tgt_sda = ~pat[k];  // R5: between sample instants, ignored
      repeat (G - 1) @(negedge clk);
    end
    tgt_sda = 1'b1;
    wait_valid(seen);
    chk(seen, "R11 result strobe", seen, 1);
    chk(err == e[1:0], "R6/R7/R8 R4 R5 error code", err, e[1:0]);
    chk(rbit == e[2], "R6/R7/R8 R4 R5 bit", rbit, e[2]);
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    @(negedge clk);
    chk(!valid, "R11 single pulse", valid, 0);
    chk(!scl_oe && !sda_oe, "R10 released after result", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    logic [NS-1:0] p;
    bit seen;
    unused_seed = $urandom(32'h1a2b);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !scl_oe && !sda_oe, "reset state", {valid, scl_oe, sda_oe}, 0);

    // R1 bad state
    bus_act = 1'b0;
    pulse_req();
    chk(valid && err == 2'd1, "R1 bad state code", err, 1);
    chk(!rbit, "R1 bit zero", rbit, 0);
    chk(!scl_oe && !sda_oe, "R1 lines untouched", {scl_oe, sda_oe}, 0);
    bus_act = 1'b1;
    @(negedge clk);

    // directed band edges R6 R7 R8
    run_bit(8'h00, 0, 0);
    run_bit(8'h10, 0, 0);   // 1 high -> 0
    run_bit(8'h11, 0, 0);   // 2 high -> error
    run_bit(8'h1f, 0, 0);   // 5 high -> error
    run_bit(8'h3f, 0, 0);   // 6 high -> 1
    run_bit(8'hff, 0, 0);
    // R9 stretch at the limit still accepted, R4
    run_bit(8'hff, LIM, LIM);

    // R9 lock in first wait
    tgt_hold = 1'b1;
    pulse_req();
    wait_valid(seen);
    chk(seen && err == 2'd2, "R9 lock first wait", err, 2);
    chk(!scl_oe, "R9 R10 released after lock", scl_oe, 0);
    tgt_hold = 1'b0;
    repeat (2) @(negedge clk);

    // R9 lock in stretch wait
    pulse_req();
    for (int g = 0; g < 20 && !scl_oe; g++) @(negedge clk);
    while (scl_oe) @(negedge clk);
    tgt_hold = 1'b1;
    wait_valid(seen);
    chk(seen && err == 2'd2, "R9 lock stretch wait", err, 2);
    tgt_hold = 1'b0;
    repeat (2) @(negedge clk);

    // random patterns and stretches
    for (int n = 0; n < 40; n++) begin
      p = NS'($urandom);
      if (n % 4 == 0) p = ($urandom % 2) ? '1 : '0;
      run_bit(p, int'($urandom % (LIM + 1)), int'($urandom % (LIM + 1)));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule